// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one PWM command into a pair of complementary gate-drive logic signals, a high-side output and a low-side output. A high command drives the high-side output and releases the low-side output. A low command does the reverse. Each time the command changes level, the output that is conducting is switched off first. The opposite output is switched on only after a programmable number of cycles in which both outputs are low, so the two outputs are never high together.

An optional persistence filter can be placed in front of the sequencer to reject short noise pulses on the command. Turning the filter on adds a fixed latency. A single gate condition forces both outputs low at once. That condition is the product of an enable input and a permit input, which comes from an external supply supervisor. After the gate comes back, the first output to turn on waits a full dead interval.

The programmable dead length is clamped into one of two ranges, chosen by a parameter when the block is built. A bench-driven or register-driven count sets the length.

Top module: `pwm_deadband_gen`

## Requirements
- R1: With the gate open and the command held steady, a high `pwm_in` gives `hs_out`=1 and `ls_out`=0, and a low `pwm_in` gives `hs_out`=0 and `ls_out`=1.
- R2: With deglitch off, the conducting output goes low 3 clock edges after the edge that first samples the new `pwm_in` level, counted from the first edge after the change.
- R3: The opposite output rises exactly D edges after the edge that switched the conducting output off, and both outputs are low in between. D is the clamped dead length.
- R4: D equals `dt_count` clamped to [1, 20] when RANGE_SEL=0 and to [4, 40] when RANGE_SEL=1. A count of 0 is therefore treated as 1 in the short range.
- R5: With `deglitch_en`=1, a `pwm_in` pulse lasting fewer than GLITCH_CYC (default 3) sampled cycles has no effect on either output. A longer change passes, and every latency grows by GLITCH_CYC-1 edges.
- R6: When `enable` or `permit` is low at an edge, both outputs are low after that edge, and changes on `pwm_in` have no effect on the outputs while the gate stays closed.
- R7: When the gate reopens, the output selected by the command rises D edges after the first edge that sees the gate open.
- R8: If the filtered command reverses during a dead interval, the pending output is cancelled and a full new dead interval is counted for the new direction. With deglitch off, a one-cycle pulse makes the low-side output fall after 3 edges and return after 4+D edges, and `hs_out` never rises.
- R9: `hs_out` and `ls_out` are never high in the same cycle.
- R10: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command, high selects the high-side output |
| enable | input | 1 | Active-high run enable |
| permit | input | 1 | Supply-good permission from an external supervisor |
| dt_count | input | DT_W | Requested dead length in clock cycles |
| deglitch_en | input | 1 | Enables the persistence filter on `pwm_in` |
| hs_out | output | 1 | High-side gate-drive logic output |
| ls_out | output | 1 | Low-side gate-drive logic output |

## Verification
A corrupt sequencer state shows up at the ports within one dead interval. It appears as an output rising too early or too late, or as a missing rise, and the bench measures each of these edge latencies to the exact cycle. A filter counter that is stuck or off by one moves both the turn-off latency and the pulse-rejection threshold by one cycle, so the sweep across pulse widths exposes it within a few cycles. An overlap of the two outputs, or a rise with fewer than the minimum dead cycles, is caught on the edge where it happens.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

   // sequencer phases
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,   // gate closed, both outputs held low
      ST_DEAD = 2'd1,   // both low, counting toward the pending side
      ST_HI   = 2'd2,   // high-side output conducting
      ST_LO   = 2'd3    // low-side output conducting
   } dt_state_e;

endpackage

// File: rtl/pwm_in_filter.sv
// Samples the PWM command and optionally applies a persistence filter.
// A new level is accepted once it has been sampled GLITCH_CYC times in a row.
module pwm_in_filter #(
   parameter int GLITCH_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_raw,
   input  logic dg_en,
   output logic pwm_clean
);

   localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC + 1) : 1;

   logic samp;
   logic filt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp <= 1'b0;
      else        samp <= pwm_raw;
   end

   generate
      if (GLITCH_CYC > 1) begin : g_persist
         logic [CW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt <= 1'b0;
               run  <= '0;
            end else if (!dg_en) begin
               filt <= samp;
               run  <= '0;
            end else if (samp == filt) begin
               run  <= '0;
            end else if (run == CW'(GLITCH_CYC - 1)) begin
               filt <= samp;
               run  <= '0;
            end else begin
               run  <= run + 1'b1;
            end
         end
      end else begin : g_direct
         logic unused_dg;
         assign unused_dg = dg_en;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt <= 1'b0;
            else        filt <= samp;
         end
      end
   endgenerate

   assign pwm_clean = filt;

endmodule

// File: rtl/dt_limit.sv
// Clamps the requested dead length into the range picked by RANGE_SEL.
module dt_limit #(
   parameter int DT_W      = 6,
   parameter int RANGE_SEL = 0,
   parameter int SHORT_LO  = 1,
   parameter int SHORT_HI  = 20,
   parameter int LONG_LO   = 4,
   parameter int LONG_HI   = 40
) (
   input  logic [DT_W-1:0] req,
   output logic [DT_W-1:0] lim
);

   generate
      if (RANGE_SEL == 0) begin : g_short
         always_comb begin
            if (req < DT_W'(SHORT_LO))      lim = DT_W'(SHORT_LO);
            else if (req > DT_W'(SHORT_HI)) lim = DT_W'(SHORT_HI);
            else                            lim = req;
         end
      end else begin : g_long
         always_comb begin
            if (req < DT_W'(LONG_LO))       lim = DT_W'(LONG_LO);
            else if (req > DT_W'(LONG_HI))  lim = DT_W'(LONG_HI);
            else                            lim = req;
         end
      end
   endgenerate

endmodule

// File: rtl/dt_sequencer.sv
// Break-before-make sequencer: the conducting side drops at once, and the
// other side rises after dlen cycles with both outputs low.
module dt_sequencer
   import pwm_dt_pkg::*;
#(
   parameter int DT_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gate,
   input  logic            level,
   input  logic [DT_W-1:0] dlen_in,
   output logic            hs,
   output logic            ls
);

   dt_state_e       st;
   logic            tgt;
   logic [DT_W-1:0] cnt;
   logic [DT_W-1:0] dlen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_OFF;
         hs   <= 1'b0;
         ls   <= 1'b0;
         tgt  <= 1'b0;
         cnt  <= '0;
         dlen <= DT_W'(1);
      end else if (!gate) begin
         st  <= ST_OFF;
         hs  <= 1'b0;
         ls  <= 1'b0;
         cnt <= '0;
      end else begin
         case (st)
            ST_OFF: begin
               st   <= ST_DEAD;
               tgt  <= level;
               cnt  <= DT_W'(1);
               dlen <= dlen_in;
            end
            ST_DEAD: begin
               if (level != tgt) begin
                  // reversal: cancel pending side, restart the interval
                  tgt  <= level;
                  cnt  <= DT_W'(1);
                  dlen <= dlen_in;
               end else if (cnt >= dlen) begin
                  st <= tgt ? ST_HI : ST_LO;
                  hs <= tgt;
                  ls <= !tgt;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HI: begin
               if (!level) begin
                  hs   <= 1'b0;
                  st   <= ST_DEAD;
                  tgt  <= 1'b0;
                  cnt  <= DT_W'(1);
                  dlen <= dlen_in;
               end
            end
            default: begin
               if (level) begin
                  ls   <= 1'b0;
                  st   <= ST_DEAD;
                  tgt  <= 1'b1;
                  cnt  <= DT_W'(1);
                  dlen <= dlen_in;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pwm_deadband_gen.sv
// Complementary PWM dead-time generator, top level.
module pwm_deadband_gen #(
   parameter int DT_W       = 6,
   parameter int RANGE_SEL  = 0,
   parameter int GLITCH_CYC = 3,
   parameter int SHORT_LO   = 1,
   parameter int SHORT_HI   = 20,
   parameter int LONG_LO    = 4,
   parameter int LONG_HI    = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwm_in,
   input  logic            enable,
   input  logic            permit,
   input  logic [DT_W-1:0] dt_count,
   input  logic            deglitch_en,
   output logic            hs_out,
   output logic            ls_out
);

   localparam int DT_LO = (RANGE_SEL == 0) ? SHORT_LO : LONG_LO;
   localparam int DT_HI = (RANGE_SEL == 0) ? SHORT_HI : LONG_HI;

   // elaboration-time parameter checks
   generate
      if (RANGE_SEL != 0 && RANGE_SEL != 1) begin : g_bad_range
         $error("RANGE_SEL must be 0 or 1");
      end
      if (DT_LO < 1 || DT_HI < DT_LO) begin : g_bad_bounds
         $error("dead length bounds are inconsistent");
      end
      if (DT_HI >= (1 << DT_W)) begin : g_bad_width
         $error("DT_W too narrow for the upper dead length");
      end
      if (GLITCH_CYC < 1) begin : g_bad_glitch
         $error("GLITCH_CYC must be at least 1");
      end
   endgenerate

   logic            cmd_clean;
   logic [DT_W-1:0] dlen;
   logic            gate;

   assign gate = enable & permit;

   pwm_in_filter #(
      .GLITCH_CYC (GLITCH_CYC)
   ) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_raw   (pwm_in),
      .dg_en     (deglitch_en),
      .pwm_clean (cmd_clean)
   );

   dt_limit #(
      .DT_W      (DT_W),
      .RANGE_SEL (RANGE_SEL),
      .SHORT_LO  (SHORT_LO),
      .SHORT_HI  (SHORT_HI),
      .LONG_LO   (LONG_LO),
      .LONG_HI   (LONG_HI)
   ) u_limit (
      .req (dt_count),
      .lim (dlen)
   );

   dt_sequencer #(
      .DT_W (DT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate    (gate),
      .level   (cmd_clean),
      .dlen_in (dlen),
      .hs      (hs_out),
      .ls      (ls_out)
   );

endmodule

// File: rtl/pwm_deadband_chk.sv
// Port-level checker for the dead-time generator.
module pwm_deadband_chk #(
   parameter int DT_LO = 1
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic permit,
   input logic hs_out,
   input logic ls_out
);

   // consecutive cycles with both outputs low, saturating
   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_run <= '0;
      else if (hs_out || ls_out) low_run <= '0;
      else if (low_run != '1)    low_run <= low_run + 1'b1;
   end

   // R9: never both high
   a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_out && ls_out));

   // R6: closed gate forces both low on the next cycle
   a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(enable && permit) |=> (!hs_out && !ls_out));

   // R6: an output can only rise if the gate was open on the edge before
   a_r6_rise_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_out) || $rose(ls_out)) |-> $past(enable && permit));

   // R3: high-side rise preceded by at least the minimum dead length
   a_r3_min_dead_hs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_out) |-> (low_run >= 16'(DT_LO)));

   // R3: low-side rise preceded by at least the minimum dead length
   a_r3_min_dead_ls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_out) |-> (low_run >= 16'(DT_LO)));

endmodule

bind pwm_deadband_gen pwm_deadband_chk #(.DT_LO(DT_LO)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .enable (enable),
   .permit (permit),
   .hs_out (hs_out),
   .ls_out (ls_out)
);

// File: tb/test_pwm_deadband_gen.sv
module test_pwm_deadband_gen;

   localparam int DT_W = 6;
   localparam int G    = 3;
   localparam int LO   = 1;
   localparam int HI   = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pwm_in = 1'b0;
   logic            enable = 1'b0;
   logic            permit = 1'b0;
   logic            deglitch_en = 1'b0;
   logic [DT_W-1:0] dt_count = '0;
   logic            hs_out;
   logic            ls_out;

   pwm_deadband_gen #(
      .DT_W (DT_W), .RANGE_SEL (0), .GLITCH_CYC (G)
   ) i_pwm_deadband_gen (
      .clk (clk), .rst_n (rst_n), .pwm_in (pwm_in), .enable (enable),
      .permit (permit), .dt_count (dt_count), .deglitch_en (deglitch_en),
      .hs_out (hs_out), .ls_out (ls_out)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   int overlap = 0;
   int hs_hi = 0;
   int ls_lo = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (hs_out && ls_out) overlap++;
      if (hs_out) hs_hi++;
      if (!ls_out) ls_lo++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int dclamp(input int v);
      if (v < LO) return LO;
      if (v > HI) return HI;
      return v;
   endfunction

   // waits until the chosen output equals val, returns cycles since t0
   task automatic edge_lat(input bit sel_hs, input bit val, input int t0,
                           output int lat);
      int k = 0;
      while (((sel_hs ? hs_out : ls_out) !== val) && k < 300) begin
         @(negedge clk);
         k++;
      end
      lat = cyc - t0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         report();
         $finish;
      end
   end

   initial begin
      int dts[8] = '{0, 1, 2, 3, 7, 20, 21, 63};
      int t0, lat, d, off_exp;

      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 hs in reset", hs_out, 0);
      chk("R10 ls in reset", ls_out, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 hs gate closed after reset", hs_out, 0);
      chk("R6 ls gate closed after reset", ls_out, 0);
      enable = 1'b1;
      permit = 1'b1;

      // R1 R2 R3 R4 R5: sweep dead length and deglitch on both edges
      for (int dg = 0; dg < 2; dg++) begin
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            deglitch_en = dg[0];
            dt_count = DT_W'(dts[i]);
            pwm_in = 1'b0;
            repeat (40) @(negedge clk);
            d = dclamp(dts[i]);
            off_exp = 3 + (dg != 0 ? G - 1 : 0);
            chk("R1 ls high for low command", ls_out, 1);
            chk("R1 hs low for low command", hs_out, 0);
            t0 = cyc;
            pwm_in = 1'b1;
            edge_lat(1'b0, 1'b0, t0, lat);
            chk("R2 R5 low-side turn-off latency", lat, off_exp);
            edge_lat(1'b1, 1'b1, t0, lat);
            chk("R3 R4 high-side turn-on latency", lat, off_exp + d);
            repeat (40) @(negedge clk);
            chk("R1 hs high for high command", hs_out, 1);
            chk("R1 ls low for high command", ls_out, 0);
            t0 = cyc;
            pwm_in = 1'b0;
            edge_lat(1'b1, 1'b0, t0, lat);
            chk("R2 R5 high-side turn-off latency", lat, off_exp);
            edge_lat(1'b0, 1'b1, t0, lat);
            chk("R3 R4 low-side turn-on latency", lat, off_exp + d);
         end
      end

      // R5: pulses shorter than G are rejected, a G-cycle pulse passes
      deglitch_en = 1'b1;
      dt_count = DT_W'(4);
      for (int w = 1; w <= G; w++) begin
         repeat (40) @(negedge clk);
         ls_lo = 0;
         hs_hi = 0;
         pwm_in = 1'b1;
         repeat (w) @(negedge clk);
         pwm_in = 1'b0;
         repeat (30) @(negedge clk);
         if (w < G) begin
            chk("R5 short pulse leaves ls high", ls_lo, 0);
            chk("R5 short pulse leaves hs low", hs_hi, 0);
         end else begin
            chk("R5 full-width pulse reaches outputs", ls_lo > 0, 1);
         end
      end

      // R8: reversal during dead interval, one-cycle pulse, deglitch off
      deglitch_en = 1'b0;
      for (int j = 0; j < 2; j++) begin
         dt_count = (j == 0) ? DT_W'(5) : DT_W'(1);
         d = dclamp(int'(dt_count));
         repeat (40) @(negedge clk);
         hs_hi = 0;
         t0 = cyc;
         pwm_in = 1'b1;
         @(negedge clk);
         pwm_in = 1'b0;
         edge_lat(1'b0, 1'b0, t0, lat);
         chk("R8 ls falls on pulse", lat, 3);
         edge_lat(1'b0, 1'b1, t0, lat);
         chk("R8 ls returns after restarted interval", lat, 4 + d);
         repeat (10) @(negedge clk);
         chk("R8 hs never rises on cancelled pulse", hs_hi, 0);
      end

      // R6 R7: enable drop and restore with high command
      dt_count = DT_W'(6);
      pwm_in = 1'b1;
      repeat (40) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R6 hs low one edge after enable drop", hs_out, 0);
      chk("R6 ls low one edge after enable drop", ls_out, 0);
      pwm_in = 1'b0;
      repeat (8) @(negedge clk);
      pwm_in = 1'b1;
      hs_hi = 0;
      ls_lo = 0;
      repeat (8) @(negedge clk);
      chk("R6 command ignored while disabled hs", hs_hi, 0);
      chk("R6 command ignored while disabled ls", ls_lo, 8);
      t0 = cyc;
      enable = 1'b1;
      edge_lat(1'b1, 1'b1, t0, lat);
      chk("R7 hs rise after enable restore", lat, 1 + 6);

      // R6 R7: permit drop and restore with low command
      pwm_in = 1'b0;
      repeat (40) @(negedge clk);
      permit = 1'b0;
      @(negedge clk);
      chk("R6 ls low one edge after permit drop", ls_out, 0);
      repeat (5) @(negedge clk);
      t0 = cyc;
      permit = 1'b1;
      edge_lat(1'b0, 1'b1, t0, lat);
      chk("R7 ls rise after permit restore", lat, 1 + 6);

      repeat (5) @(negedge clk);
      chk("R9 no cycle with both outputs high", overlap, 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule